// File: doc/BRIEF.md
# Infrared Carrier Period and Duty Sensor

This block watches a raw, still-modulated infrared input and measures its carrier. A reference tick of one tick every `TICK_DIV` clocks, a 500 ns tick at the default clock, sets the unit of measure. The block counts ticks from one rising carrier edge to the next (the period) and from a rising edge to the following falling edge (the high time). After a programmable number of settling cycles in a burst, each completed cycle is latched into a period result and a high-time result. The top bit of the period result is a valid flag. Software derives the carrier frequency as the tick rate divided by the period, and the duty as high time times 100 over period.

The same tracking logic also produces a demodulated envelope. The envelope goes high with the first carrier edge of a burst and stays high while rising edges keep arriving within twice the last measured period. When demodulation is off, the envelope output is the synchronised raw input.

A controller (`ircs_measure`) runs three states. `ST_IDLE` has no carrier. `ST_FIRST` is the first cycle of a burst, with no period known yet. `ST_TRACK` means a period has been measured. The transitions are:
- START (`ST_IDLE`→`ST_FIRST`): a rising edge while the block is enabled.
- LOCK (`ST_FIRST`→`ST_TRACK`): a rising edge closes a cycle of 1 to 127 ticks.
- RELOCK (`ST_TRACK`→`ST_FIRST`): a rising edge closes a cycle longer than 127 ticks.
- LOST (`ST_FIRST`/`ST_TRACK`→`ST_IDLE`): the timeout expires.
- HALT (any state→`ST_IDLE`): both enables are low.

A rising edge that closes a zero-tick cycle is a GLITCH. It restarts the cycle count without changing state.

Top module: `ir_carrier_sense`

## Requirements
- R1: During and straight after reset, `period_reg`, `high_reg` and `env_out` are all zero.
- R2: On a latch, `period_reg[6:0]` = floor(N / TICK_DIV) and `period_reg[7]` = 1, where N is the count of clocks between two successive rising edges of the input.
- R3: On the same latch, `high_reg[6:0]` = floor(H / TICK_DIV) and `high_reg[7]` = 0, where H is the count of clocks the input stayed high in that cycle. The latched high value never exceeds the latched period.
- R4: Within a burst, cycles are numbered from 0, starting at the first rising edge. Only cycles whose number is at least `pulse_cfg` are latched.
- R5: A cycle that measures zero ticks is never latched, and the valid flag stays clear.
- R6: A cycle of 127 ticks is latched. A cycle longer than 127 ticks is never latched.
- R7: A one-cycle `rd_period` pulse clears `period_reg[7]` on the next clock and leaves `period_reg[6:0]` and `high_reg` unchanged. The next completed measurement sets the flag again.
- R8: While `detect_en` is 0, nothing is latched, even if `demod_en` keeps the tracker running.
- R9: With `demod_en` = 1, `env_out` rises one clock after a synchronised rising edge starts a burst. It holds while each new rising edge comes within 2× the last measured period, counted in ticks. In the first cycle of a burst the limit is 127 ticks. Once the limit is exceeded, `env_out` falls.
- R10: With `demod_en` = 0, `env_out` equals `ir_raw` delayed by two clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_raw | input | 1 | Raw modulated IR input, asynchronous |
| detect_en | input | 1 | Enables latching of measurements |
| demod_en | input | 1 | Selects the demodulated envelope on `env_out` |
| pulse_cfg | input | 8 | Number of settling cycles skipped at burst start |
| rd_period | input | 1 | One-cycle read strobe that clears the valid flag |
| period_reg | output | 8 | {valid, period in ticks} |
| high_reg | output | 8 | {0, high time in ticks} |
| env_out | output | 1 | Demodulated envelope, or the synchronised raw input |

## Verification
The bench goes after the tick-rounding edges:
- A high time that is not a whole number of ticks must round down. A design that restarted its tick divider late would read one tick low on every exact period.
- A two-clock glitch cycle must stay unlatched. A design without the zero check would report period 0 with the valid flag set.
- At the range boundary, 127 ticks must latch and 129 must never latch. A wrapping counter would report a small bogus period.
- With `pulse_cfg` greater than the number of completed cycles, nothing may latch. An off-by-one in cycle numbering would latch anyway.

For the envelope, the bench holds the input low past one timeout and checks that the output drops. A design that never timed out would keep it high forever. The bench then confirms that demodulation off gives the raw input back, and that the read strobe clears only the flag.

// File: rtl/ircs_pkg.sv
package ircs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_TRACK = 2'd2
    } ircs_state_e;

endpackage

// File: rtl/ircs_tick_gen.sv
module ircs_tick_gen #(
    parameter int TICK_DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int TW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [TW-1:0] LAST = TW'(TICK_DIV - 1);

    logic [TW-1:0] cnt_q;

    // Restart loads 1 so the first tick lands TICK_DIV-1 clocks after the edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= TW'(1);
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + TW'(1);
        end
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/ircs_edge_sync.sv
module ircs_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ir_raw,
    output logic ir_sync,
    output logic rise,
    output logic fall
);
    logic [SYNC_STAGES-1:0] sh_q;
    logic                   prev_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= ir_raw;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= {sh_q[SYNC_STAGES-2:0], ir_raw};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sh_q[SYNC_STAGES-1];
    end

    assign ir_sync = sh_q[SYNC_STAGES-1];
    assign rise    = ir_sync & ~prev_q;
    assign fall    = ~ir_sync & prev_q;
endmodule

// File: rtl/ircs_measure.sv
module ircs_measure
    import ircs_pkg::*;
#(
    parameter int PER_W = 7,
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             rise,
    input  logic             fall,
    input  logic [CFG_W-1:0] pulse_cfg,
    output ircs_state_e      state,
    output logic             meas_stb,
    output logic [PER_W-1:0] meas_per,
    output logic [PER_W-1:0] meas_high
);
    localparam int          CW      = PER_W + 1;
    localparam logic [CW-1:0] PER_MAX = CW'((1 << PER_W) - 1);

    ircs_state_e      state_q, state_n;
    logic [CW-1:0]    per_cnt_q;
    logic [PER_W-1:0] hi_cnt_q, hi_len_q, last_per_q;
    logic [CFG_W-1:0] cyc_cnt_q;
    logic             in_high_q;

    logic             cycle_ok, too_long, timeout, active, edge_in;
    logic [CW-1:0]    limit;

    assign active   = (state_q != ST_IDLE);
    assign edge_in  = run && rise;
    assign cycle_ok = (per_cnt_q != '0) && (per_cnt_q <= PER_MAX);
    assign too_long = (per_cnt_q > PER_MAX);
    assign limit    = (state_q == ST_TRACK) ? {last_per_q, 1'b0} : PER_MAX;
    assign timeout  = (per_cnt_q > limit);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (edge_in) state_n = ST_FIRST;               // START
            end
            ST_FIRST: begin
                if (!run)                      state_n = ST_IDLE;  // HALT
                else if (rise && cycle_ok)     state_n = ST_TRACK; // LOCK
                else if (!rise && timeout)     state_n = ST_IDLE;  // LOST
            end
            ST_TRACK: begin
                if (!run)                      state_n = ST_IDLE;  // HALT
                else if (rise && too_long)     state_n = ST_FIRST; // RELOCK
                else if (!rise && timeout)     state_n = ST_IDLE;  // LOST
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        meas_stb  = edge_in && active && cycle_ok && (cyc_cnt_q >= pulse_cfg);
        meas_per  = per_cnt_q[PER_W-1:0];
        meas_high = hi_len_q;
        state     = state_q;
    end

    // counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_cnt_q  <= '0;
            hi_cnt_q   <= '0;
            hi_len_q   <= '0;
            last_per_q <= '0;
            cyc_cnt_q  <= '0;
            in_high_q  <= 1'b0;
        end else if (edge_in) begin
            per_cnt_q <= '0;
            hi_cnt_q  <= '0;
            in_high_q <= 1'b1;
            if (!active || too_long) begin
                cyc_cnt_q <= '0;
            end else if (cycle_ok) begin
                last_per_q <= per_cnt_q[PER_W-1:0];
                if (cyc_cnt_q != '1) cyc_cnt_q <= cyc_cnt_q + CFG_W'(1);
            end
        end else begin
            if (tick && active && (per_cnt_q != '1))
                per_cnt_q <= per_cnt_q + CW'(1);
            if (fall) begin
                in_high_q <= 1'b0;
                hi_len_q  <= hi_cnt_q;
            end else if (tick && in_high_q && (hi_cnt_q != '1)) begin
                hi_cnt_q <= hi_cnt_q + PER_W'(1);
            end
        end
    end
endmodule

// File: rtl/ircs_result_regs.sv
module ircs_result_regs #(
    parameter int PER_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             detect_en,
    input  logic             meas_stb,
    input  logic [PER_W-1:0] meas_per,
    input  logic [PER_W-1:0] meas_high,
    input  logic             rd_clr,
    output logic [PER_W:0]   period_reg,
    output logic [PER_W:0]   high_reg
);
    logic             valid_q;
    logic [PER_W-1:0] per_q, hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            per_q   <= '0;
            hi_q    <= '0;
        end else if (meas_stb && detect_en) begin
            valid_q <= 1'b1;
            per_q   <= meas_per;
            hi_q    <= meas_high;
        end else if (rd_clr) begin
            valid_q <= 1'b0;
        end
    end

    assign period_reg = {valid_q, per_q};
    assign high_reg   = {1'b0, hi_q};
endmodule

// File: rtl/ir_carrier_sense.sv
module ir_carrier_sense
    import ircs_pkg::*;
#(
    parameter int TICK_DIV    = 100,
    parameter int PER_W       = 7,
    parameter int CFG_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ir_raw,
    input  logic             detect_en,
    input  logic             demod_en,
    input  logic [CFG_W-1:0] pulse_cfg,
    input  logic             rd_period,
    output logic [PER_W:0]   period_reg,
    output logic [PER_W:0]   high_reg,
    output logic             env_out
);
    logic             ir_sync, edge_rise, edge_fall, tick, run, meas_stb;
    logic [PER_W-1:0] meas_per, meas_high;
    ircs_state_e      trk_state;

    assign run = detect_en | demod_en;

    ircs_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .ir_raw(ir_raw),
        .ir_sync(ir_sync), .rise(edge_rise), .fall(edge_fall)
    );

    ircs_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(edge_rise & run), .tick(tick)
    );

    ircs_measure #(.PER_W(PER_W), .CFG_W(CFG_W)) u_meas (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
        .rise(edge_rise), .fall(edge_fall), .pulse_cfg(pulse_cfg),
        .state(trk_state), .meas_stb(meas_stb),
        .meas_per(meas_per), .meas_high(meas_high)
    );

    ircs_result_regs #(.PER_W(PER_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .detect_en(detect_en),
        .meas_stb(meas_stb), .meas_per(meas_per), .meas_high(meas_high),
        .rd_clr(rd_period), .period_reg(period_reg), .high_reg(high_reg)
    );

    assign env_out = demod_en ? (trk_state != ST_IDLE) : ir_sync;
endmodule

// File: rtl/ircs_checker.sv
module ircs_checker #(
    parameter int PER_W = 7
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ir_raw,
    input logic           detect_en,
    input logic           demod_en,
    input logic           rd_period,
    input logic [PER_W:0] period_reg,
    input logic [PER_W:0] high_reg,
    input logic           env_out,
    input logic           meas_stb,
    input logic           edge_rise
);
    logic [1:0] settle_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              settle_q <= '0;
        else if (settle_q != '1) settle_q <= settle_q + 2'd1;
    end

    // R1: results zero while reset is held
    always @(negedge clk) begin
        if (!rst_n) begin
            p_reset_zero_r1: assert (period_reg == '0 && high_reg == '0);
        end
    end

    // R3: latched high time never exceeds latched period
    p_high_le_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
        period_reg[PER_W] |-> (high_reg[PER_W-1:0] <= period_reg[PER_W-1:0]));

    // R5: a valid result never carries a zero period
    p_nonzero_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
        period_reg[PER_W] |-> (period_reg[PER_W-1:0] != '0));

    // R7: a read with no competing latch clears the flag
    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_period && !meas_stb) |=> !period_reg[PER_W]);

    // R8: the flag only rises after an enabled measurement
    p_latch_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(period_reg[PER_W]) |-> $past(detect_en && meas_stb));

    // R9: with demodulation held on, the envelope starts only from an edge
    p_env_from_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (demod_en && $past(demod_en) && $rose(env_out)) |-> $past(edge_rise));

    // R10: without demodulation the output is the input two clocks late
    p_raw_passthru_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_q == 2'd3 && !demod_en) |-> (env_out == $past(ir_raw, 2)));
endmodule

bind ir_carrier_sense ircs_checker #(.PER_W(PER_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ir_raw(ir_raw), .detect_en(detect_en),
    .demod_en(demod_en), .rd_period(rd_period), .period_reg(period_reg),
    .high_reg(high_reg), .env_out(env_out), .meas_stb(meas_stb),
    .edge_rise(edge_rise)
);

// File: tb/ir_carrier_sense_tb_top.sv
module ir_carrier_sense_tb_top;
    localparam int TD = 4;
    localparam int NV = 7;
    // period clocks, high clocks, cycles, pulse_cfg, exp valid, exp period, exp high
    localparam int VEC [NV][7] = '{
        '{104,  52, 4, 0, 1,  26, 13},
        '{ 40,  12, 5, 2, 1,  10,  3},
        '{508, 200, 3, 0, 1, 127, 50},
        '{ 60,  45, 4, 1, 1,  15, 11},
        '{  8,   4, 4, 0, 1,   2,  1},
        '{100,  30, 4, 3, 0,   0,  0},
        '{516, 100, 3, 0, 0,   0,  0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ir_raw = 1'b0;
    logic       detect_en = 1'b0;
    logic       demod_en = 1'b0;
    logic [7:0] pulse_cfg = 8'd0;
    logic       rd_period = 1'b0;
    logic [7:0] period_reg, high_reg;
    logic       env_out;
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    ir_carrier_sense #(.TICK_DIV(TD)) dut_i (
        .clk(clk), .rst_n(rst_n), .ir_raw(ir_raw), .detect_en(detect_en),
        .demod_en(demod_en), .pulse_cfg(pulse_cfg), .rd_period(rd_period),
        .period_reg(period_reg), .high_reg(high_reg), .env_out(env_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic carrier(input int p, input int h, input int n);
        for (int i = 0; i < n; i++) begin
            ir_raw = 1'b1;
            wait_clk(h);
            ir_raw = 1'b0;
            wait_clk(p - h);
        end
    endtask

    task automatic read_strobe();
        rd_period = 1'b1;
        wait_clk(1);
        rd_period = 1'b0;
    endtask

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(1);
        chk("R1 period_reg", period_reg, 0);
        chk("R1 high_reg", high_reg, 0);
        chk("R1 env_out", env_out, 0);

        // vector table
        detect_en = 1'b1;
        for (int v = 0; v < NV; v++) begin
            pulse_cfg = 8'(VEC[v][3]);
            carrier(VEC[v][0], VEC[v][1], VEC[v][2]);
            wait_clk(1100);
            chk($sformatf("R4/R6 valid row %0d", v), period_reg[7], VEC[v][4]);
            if (VEC[v][4] == 1) begin
                chk($sformatf("R2/R6 period row %0d", v), period_reg[6:0], VEC[v][5]);
                chk($sformatf("R3 high row %0d", v), high_reg, VEC[v][6]);
                read_strobe();
                chk($sformatf("R7 valid cleared row %0d", v), period_reg[7], 0);
                chk($sformatf("R7 period kept row %0d", v), period_reg[6:0], VEC[v][5]);
                chk($sformatf("R7 high kept row %0d", v), high_reg, VEC[v][6]);
            end
        end

        // zero-tick glitch cycle
        pulse_cfg = 8'd0;
        ir_raw = 1'b1; wait_clk(1);
        ir_raw = 1'b0; wait_clk(1);
        ir_raw = 1'b1; wait_clk(1);
        ir_raw = 1'b0;
        wait_clk(1100);
        chk("R5 zero period not latched", period_reg[7], 0);

        // detection disabled, demod keeps tracker running
        detect_en = 1'b0;
        demod_en  = 1'b1;
        carrier(104, 52, 4);
        wait_clk(1100);
        chk("R8 no latch when detect off", period_reg[7], 0);

        // envelope hold and timeout in tracking
        carrier(40, 20, 6);
        chk("R9 env high in burst", env_out, 1);
        wait_clk(30);
        chk("R9 env held within 2 periods", env_out, 1);
        wait_clk(40);
        chk("R9 env fell after timeout", env_out, 0);

        // envelope first-cycle limit
        ir_raw = 1'b1; wait_clk(10);
        ir_raw = 1'b0; wait_clk(190);
        chk("R9 env held in first cycle", env_out, 1);
        wait_clk(400);
        chk("R9 env fell after first-cycle limit", env_out, 0);

        // demodulation off: raw passthrough
        demod_en = 1'b0;
        detect_en = 1'b1;
        ir_raw = 1'b1; wait_clk(3);
        chk("R10 env follows raw high", env_out, 1);
        ir_raw = 1'b0; wait_clk(3);
        chk("R10 env follows raw low", env_out, 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule